// File: doc/BRIEF.md
# Iterative Multi-Mode Integer Divider

This block is the divide unit of a 64-bit execution pipeline. It takes one division request at a time and returns a quotient or a remainder some cycles later. A request holds a dividend, a divisor and five mode bits. The mode bits select word or doubleword width, shifted-dividend (extended) division, remainder instead of quotient, signed handling, and negation of the final result. The requester strips the signs from the operands before sending them. The divider therefore always works on magnitudes, and a single negate bit from the requester sets the final sign.

The core is a radix-2 restoring loop that produces one quotient bit per clock. A doubleword or extended doubleword operation takes 64 iterations and a word operation takes 32. One more cycle then corrects the sign, narrows and extends the result, and applies the overflow rules. The request is accepted when `req_valid` is high while `busy` is low. Requests that arrive while an operation is in flight are dropped.

Top module: `seq_divider`

## Requirements
- R1: A synchronous reset held for one clock makes the block idle. After it, `busy`, `res_valid`, `res_ovf` and `res_value` read 0, and an operation that was in flight never produces a result.
- R2: A request is accepted on a rising edge where `req_valid` is 1 and `busy` is 0. `res_valid` is 0 in the cycle after acceptance. It is a single-cycle pulse that rises N+1 edges after the accepting edge, where N is 32 in word mode and 64 otherwise.
- R3: With every mode bit clear, the result is the unsigned 64-bit quotient floor(a/b).
- R4: In word mode (`req_word`=1), only bits 31:0 of each operand are used. The 32-bit result is zero-extended to 64 bits when `req_signed` is 0, and sign-extended from bit 31 when `req_signed` is 1.
- R5: In extended mode (`req_ext`=1), the dividend is a·2^N, with N zero bits appended below it.
- R6: With `req_rem`=1, the result is the remainder of the selected division instead of the quotient.
- R7: With `req_negate`=1, the result is the two's complement of the magnitude, taken in N bits.
- R8: A divisor whose low N bits are zero gives `res_value`=0 with `res_ovf`=1. `res_ovf` is only ever 1 together with `res_valid`, and the result is always 0 when it is.
- R9: When the true quotient is 2^N or more (extended mode with dividend ≥ divisor), the result is 0 and `res_ovf`=1, in both quotient and remainder mode.
- R10: In signed quotient mode, overflow is flagged and the result is 0 when the quotient magnitude exceeds 2^(N-1) with `req_negate`=1, or reaches 2^(N-1) with `req_negate`=0. Remainder mode is exempt from this check.
- R11: A request presented while `busy` is 1 is ignored. It does not change the pending result and produces no extra `res_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request strobe |
| req_dividend | input | 64 | Dividend magnitude |
| req_divisor | input | 64 | Divisor magnitude |
| req_signed | input | 1 | Signed operation (overflow range and word sign extension) |
| req_ext | input | 1 | Extended (shifted-dividend) division |
| req_word | input | 1 | 32-bit operation on the low halves |
| req_rem | input | 1 | Return remainder instead of quotient |
| req_negate | input | 1 | Negate the final magnitude |
| busy | output | 1 | Operation in flight, requests ignored |
| res_valid | output | 1 | Result pulse |
| res_value | output | 64 | Quotient or remainder |
| res_ovf | output | 1 | Divide by zero or quotient out of range |

## Verification
The bench builds the divider with its default width of 64. This gives the word path (N=32) and the doubleword path (N=64) from the same instance, so both iteration counts and both extension rules appear in one run. At that width the bench's 128-bit reference covers the extended-mode boundaries, where the dividend equals or exceeds the divisor. It also covers the signed extremes, where a magnitude of exactly 2^63 or 2^31 must pass when negated and overflow when not. Random operands are shortened to random bit lengths so that quotients of every size occur. In word mode the unused upper halves carry noise.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef struct packed {
    logic sgn;
    logic ext;
    logic word;
    logic rem;
    logic neg;
  } div_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;

endpackage

// File: rtl/div_load.sv
// Forms the initial partial remainder, dividend shift register and divisor
// for the restoring loop, and flags cases that can be judged up front.
module div_load #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]         dividend,
  input  logic [XLEN-1:0]         divisor,
  input  logic                    ext,
  input  logic                    word,
  output logic [XLEN-1:0]         rem_init,
  output logic [XLEN-1:0]         quo_init,
  output logic [XLEN-1:0]         dvs_init,
  output logic [$clog2(XLEN)-1:0] iter_last,
  output logic                    early_ovf
);
  localparam int WLEN = XLEN / 2;
  localparam int CW   = $clog2(XLEN);

  logic [XLEN-1:0] a_n;
  logic [XLEN-1:0] b_n;

  always_comb begin
    if (word) begin
      a_n = {{(XLEN-WLEN){1'b0}}, dividend[WLEN-1:0]};
      b_n = {{(XLEN-WLEN){1'b0}}, divisor[WLEN-1:0]};
    end else begin
      a_n = dividend;
      b_n = divisor;
    end
  end

  always_comb begin
    if (ext) begin
      // Dividend sits entirely in the upper half of the double-width value.
      rem_init = a_n;
      quo_init = '0;
    end else begin
      rem_init = '0;
      // Word operands are left-aligned so 32 shifts consume them fully.
      quo_init = word ? (a_n << WLEN) : a_n;
    end
    dvs_init  = b_n;
    iter_last = word ? CW'(WLEN - 1) : CW'(XLEN - 1);
    // Zero divisor, or an extended quotient that needs more than N bits.
    early_ovf = (b_n == '0) || (ext && (a_n >= b_n));
  end

endmodule

// File: rtl/div_step.sv
// One restoring iteration: shift in the next dividend bit, subtract if it fits.
module div_step #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] rem_cur,
  input  logic [XLEN-1:0] quo_cur,
  input  logic [XLEN-1:0] dvs,
  output logic [XLEN-1:0] rem_nxt,
  output logic [XLEN-1:0] quo_nxt
);
  logic [XLEN:0]   trial;
  logic [XLEN-1:0] diff;
  logic            fits;

  always_comb begin
    trial   = {rem_cur, quo_cur[XLEN-1]};
    fits    = (trial >= {1'b0, dvs});
    diff    = trial[XLEN-1:0] - dvs;
    rem_nxt = fits ? diff : trial[XLEN-1:0];
    quo_nxt = {quo_cur[XLEN-2:0], fits};
  end

endmodule

// File: rtl/div_finish.sv
// Selects quotient or remainder, applies range checks, sign and width.
module div_finish
  import div_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] quo,
  input  logic [XLEN-1:0] rem,
  input  div_mode_t       mode,
  input  logic            early_ovf,
  output logic [XLEN-1:0] value,
  output logic            ovf
);
  localparam int WLEN = XLEN / 2;

  logic [XLEN-1:0] mag;
  logic [XLEN-1:0] signed_mag;
  logic [WLEN-1:0] low_part;
  logic            top_bit;
  logic            rest_nz;
  logic            range_ovf;

  always_comb begin
    mag = mode.rem ? rem : quo;
    if (mode.word) begin
      mag     = {{(XLEN-WLEN){1'b0}}, mag[WLEN-1:0]};
      top_bit = quo[WLEN-1];
      rest_nz = |quo[WLEN-2:0];
    end else begin
      top_bit = quo[XLEN-1];
      rest_nz = |quo[XLEN-2:0];
    end
    // Signed quotient: 2^(N-1) is representable only as a negative value.
    range_ovf  = mode.sgn && !mode.rem && top_bit && (!mode.neg || rest_nz);
    ovf        = early_ovf || range_ovf;
    signed_mag = mode.neg ? (~mag + 1'b1) : mag;
    low_part   = signed_mag[WLEN-1:0];
    if (ovf) begin
      value = '0;
    end else if (mode.word) begin
      value = mode.sgn ? {{(XLEN-WLEN){low_part[WLEN-1]}}, low_part}
                       : {{(XLEN-WLEN){1'b0}}, low_part};
    end else begin
      value = signed_mag;
    end
  end

endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [XLEN-1:0] req_dividend,
  input  logic [XLEN-1:0] req_divisor,
  input  logic            req_signed,
  input  logic            req_ext,
  input  logic            req_word,
  input  logic            req_rem,
  input  logic            req_negate,
  output logic            busy,
  output logic            res_valid,
  output logic [XLEN-1:0] res_value,
  output logic            res_ovf
);
  localparam int CW = $clog2(XLEN);

  div_state_e      state;
  logic [CW-1:0]   iter_cnt;
  logic [XLEN-1:0] rem_q, quo_q, dvs_q;
  div_mode_t       mode_q;
  logic            eovf_q;

  div_mode_t       mode_in;
  logic [XLEN-1:0] ld_rem, ld_quo, ld_dvs;
  logic [CW-1:0]   ld_last;
  logic            ld_ovf;
  logic [XLEN-1:0] st_rem, st_quo;
  logic [XLEN-1:0] fin_value;
  logic            fin_ovf;

  assign mode_in = '{sgn: req_signed, ext: req_ext, word: req_word,
                     rem: req_rem, neg: req_negate};

  div_load #(.XLEN(XLEN)) u_load (
    .dividend (req_dividend),
    .divisor  (req_divisor),
    .ext      (req_ext),
    .word     (req_word),
    .rem_init (ld_rem),
    .quo_init (ld_quo),
    .dvs_init (ld_dvs),
    .iter_last(ld_last),
    .early_ovf(ld_ovf)
  );

  div_step #(.XLEN(XLEN)) u_step (
    .rem_cur(rem_q),
    .quo_cur(quo_q),
    .dvs    (dvs_q),
    .rem_nxt(st_rem),
    .quo_nxt(st_quo)
  );

  div_finish #(.XLEN(XLEN)) u_finish (
    .quo      (quo_q),
    .rem      (rem_q),
    .mode     (mode_q),
    .early_ovf(eovf_q),
    .value    (fin_value),
    .ovf      (fin_ovf)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      iter_cnt  <= '0;
      rem_q     <= '0;
      quo_q     <= '0;
      dvs_q     <= '0;
      mode_q    <= '0;
      eovf_q    <= 1'b0;
      res_valid <= 1'b0;
      res_value <= '0;
      res_ovf   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      res_ovf   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            rem_q    <= ld_rem;
            quo_q    <= ld_quo;
            dvs_q    <= ld_dvs;
            mode_q   <= mode_in;
            eovf_q   <= ld_ovf;
            iter_cnt <= ld_last;
            state    <= ST_RUN;
          end
        end
        ST_RUN: begin
          rem_q    <= st_rem;
          quo_q    <= st_quo;
          iter_cnt <= iter_cnt - 1'b1;
          if (iter_cnt == '0) state <= ST_FIX;
        end
        ST_FIX: begin
          res_valid <= 1'b1;
          res_value <= fin_value;
          res_ovf   <= fin_ovf;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_signed,
  input logic            req_word,
  input logic            busy,
  input logic            res_valid,
  input logic            res_ovf,
  input logic [XLEN-1:0] res_value
);
  localparam int WLEN = XLEN / 2;
  localparam int LW   = $clog2(XLEN) + 2;

  logic          acc;
  logic          word_q;
  logic          sgn_q;
  logic [LW-1:0] lat_q;
  logic          rst_q = 1'b0;

  assign acc = req_valid && !busy;

  // Cycles since the last accepted request, counted independently of the FSM.
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      word_q <= 1'b0;
      sgn_q  <= 1'b0;
      lat_q  <= '0;
    end else if (acc) begin
      word_q <= req_word;
      sgn_q  <= req_signed;
      lat_q  <= '0;
    end else if (lat_q != '1) begin
      lat_q  <= lat_q + 1'b1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst_q |-> (!res_valid && !busy && !res_ovf));

  a_r2_quiet_after_accept: assert property (@(posedge clk) disable iff (rst)
    acc |=> !res_valid);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (lat_q == (word_q ? LW'(WLEN + 1) : LW'(XLEN + 1))));

  a_r4_word_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (res_valid && word_q && !sgn_q) |-> (res_value[XLEN-1:WLEN] == '0));

  a_r4_word_sign_ext: assert property (@(posedge clk) disable iff (rst)
    (res_valid && word_q && sgn_q) |->
      (res_value[XLEN-1:WLEN] == {(XLEN-WLEN){res_value[WLEN-1]}}));

  a_r8_ovf_with_valid: assert property (@(posedge clk) disable iff (rst)
    res_ovf |-> res_valid);

  a_r8_ovf_zero_value: assert property (@(posedge clk) disable iff (rst)
    res_ovf |-> (res_value == '0));

endmodule

bind seq_divider seq_divider_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_signed(req_signed),
  .req_word  (req_word),
  .busy      (busy),
  .res_valid (res_valid),
  .res_ovf   (res_ovf),
  .res_value (res_value)
);

// File: tb/tb_seq_divider.sv
`timescale 1ns/1ps
module tb_seq_divider;
  localparam real PERIOD = 8.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_dividend = '0;
  logic [63:0] req_divisor = '0;
  logic        req_signed = 1'b0, req_ext = 1'b0, req_word = 1'b0;
  logic        req_rem = 1'b0, req_negate = 1'b0;
  logic        busy, res_valid, res_ovf;
  logic [63:0] res_value;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  seq_divider #(.XLEN(64)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .req_dividend(req_dividend), .req_divisor(req_divisor),
    .req_signed(req_signed), .req_ext(req_ext), .req_word(req_word),
    .req_rem(req_rem), .req_negate(req_negate),
    .busy(busy), .res_valid(res_valid), .res_value(res_value), .res_ovf(res_ovf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirements with 128-bit arithmetic.
  function automatic void ref_div(input logic [63:0] a, input logic [63:0] b,
                                  input logic sg, input logic ex, input logic wd,
                                  input logic md, input logic ng,
                                  output logic [63:0] v, output logic o);
    int n;
    logic [127:0] an, bn, num, q, r, mag, lim, res;
    n  = wd ? 32 : 64;
    an = wd ? {96'b0, a[31:0]} : {64'b0, a};
    bn = wd ? {96'b0, b[31:0]} : {64'b0, b};
    v = '0;
    o = 1'b0;
    if (bn == 0) begin o = 1'b1; return; end
    num = ex ? (an << n) : an;
    q = num / bn;
    r = num % bn;
    if (q >= (128'd1 << n)) begin o = 1'b1; return; end
    if (sg && !md) begin
      lim = 128'd1 << (n - 1);
      if (ng ? (q > lim) : (q >= lim)) begin o = 1'b1; return; end
    end
    mag = md ? r : q;
    res = ng ? ((~mag + 128'd1) & ((128'd1 << n) - 128'd1)) : mag;
    if (wd) v = sg ? {{32{res[31]}}, res[31:0]} : {32'b0, res[31:0]};
    else    v = res[63:0];
  endfunction

  task automatic drive_req(input logic [63:0] a, input logic [63:0] b,
                           input logic sg, input logic ex, input logic wd,
                           input logic md, input logic ng);
    req_valid = 1'b1; req_dividend = a; req_divisor = b;
    req_signed = sg; req_ext = ex; req_word = wd; req_rem = md; req_negate = ng;
  endtask

  // Issues one request from a negedge and checks timing and result.
  task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                        input logic sg, input logic ex, input logic wd,
                        input logic md, input logic ng,
                        input string tag, input bit poke);
    logic [63:0] ev;
    logic        eo;
    int          lat;
    int          n;
    n = wd ? 32 : 64;
    ref_div(a, b, sg, ex, wd, md, ng, ev, eo);
    @(negedge clk);
    drive_req(a, b, sg, ex, wd, md, ng);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(res_valid == 1'b0, "R2", "valid low after accept", 64'(res_valid), 64'd0);
    lat = 0;
    while (!res_valid && lat < 300) begin
      if (poke && lat == 5) drive_req(~a, b ^ 64'h5, ~sg, ~ex, ~wd, ~md, ~ng);
      if (poke && lat == 6) req_valid = 1'b0;
      @(negedge clk);
      lat++;
    end
    chk(lat == n + 1, "R2", "latency", 64'(lat), 64'(n + 1));
    chk(res_value == ev, tag, "result", res_value, ev);
    chk(res_ovf == eo, tag, "overflow flag", 64'(res_ovf), 64'(eo));
    @(negedge clk);
    chk(res_valid == 1'b0, "R2", "single pulse", 64'(res_valid), 64'd0);
    if (poke) begin
      for (int i = 0; i < 70; i++) begin
        @(negedge clk);
        if (res_valid || busy) begin
          chk(1'b0, "R11", "stray activity after ignored request",
              64'({res_valid, busy}), 64'd0);
          break;
        end
      end
      chk(!busy, "R11", "idle after ignored request", 64'(busy), 64'd0);
    end
  endtask

  function automatic logic [63:0] rnd_len(input int maxb);
    logic [63:0] x;
    x = {$urandom, $urandom};
    return x >> (64 - $urandom_range(1, maxb));
  endfunction

  // Random signed or unsigned case; signed operands are converted to
  // magnitudes and a negate flag exactly as a requester would.
  task automatic random_op();
    logic sg, ex, wd, md, ng;
    logic [63:0] a, b, ma, mb;
    logic sa, sb;
    int n;
    string tag;
    sg = $urandom_range(0, 1); ex = ($urandom_range(0, 3) == 0);
    wd = $urandom_range(0, 1); md = $urandom_range(0, 1);
    n  = wd ? 32 : 64;
    a  = rnd_len(n); b = rnd_len(n);
    if ($urandom_range(0, 7) == 0) b = '0;
    if (sg) begin
      if ($urandom_range(0, 1)) a = -a;
      if ($urandom_range(0, 1)) b = -b;
      sa = wd ? a[31] : a[63];
      sb = wd ? b[31] : b[63];
      ma = sa ? -a : a;
      mb = sb ? -b : b;
      if (wd) begin ma = {32'b0, ma[31:0]}; mb = {32'b0, mb[31:0]}; end
      ng = md ? sa : (sa ^ sb);
    end else begin
      ma = a; mb = b; ng = 1'b0;
    end
    if (wd) begin
      ma[63:32] = $urandom;
      mb[63:32] = $urandom;
    end
    tag = md ? "R6" : ng ? "R7" : ex ? "R5" : wd ? "R4" : sg ? "R10" : "R3";
    run_op(ma, mb, sg, ex, wd, md, ng, tag, 1'b0);
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!res_valid, "R1", "valid after reset", 64'(res_valid), 64'd0);
    chk(!busy, "R1", "busy after reset", 64'(busy), 64'd0);
    chk(res_value == 0, "R1", "value after reset", res_value, 64'd0);

    // R3 plain unsigned doubleword
    run_op(64'h10001000, 64'h1111, 0, 0, 0, 0, 0, "R3", 0);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h3, 0, 0, 0, 0, 0, "R3", 0);
    // R4 word: upper halves ignored, zero and sign extension
    run_op(64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_0000_0001, 0, 0, 1, 0, 0, "R4", 0);
    run_op(64'hAAAA_0000_0000_0007, 64'h5555_0000_0000_0002, 1, 0, 1, 0, 1, "R4", 0);
    // R5 extended, fitting quotient: 2^64/3
    run_op(64'd1, 64'd3, 0, 1, 0, 0, 0, "R5", 0);
    run_op(64'd5, 64'd9, 0, 1, 1, 0, 0, "R5", 0);
    // R6 remainder, R7 negated signed remainder (-7 rem 2 = -1)
    run_op(64'd1000003, 64'd97, 0, 0, 0, 1, 0, "R6", 0);
    run_op(64'd7, 64'd2, 1, 0, 0, 1, 1, "R7", 0);
    // R8 divide by zero, including a word divisor with only high bits set
    run_op(64'd55, 64'd0, 0, 0, 0, 0, 0, "R8", 0);
    run_op(64'd55, 64'hFFFF_0000_0000_0000, 0, 0, 1, 1, 0, "R8", 0);
    // R9 extended quotient too large, quotient and remainder mode
    run_op(64'd9, 64'd9, 0, 1, 0, 0, 0, "R9", 0);
    run_op(64'd10, 64'd3, 0, 1, 1, 1, 0, "R9", 0);
    // R10 signed boundaries: 2^63 passes negated, overflows positive
    run_op(64'h8000_0000_0000_0000, 64'd1, 1, 0, 0, 0, 1, "R10", 0);
    run_op(64'h8000_0000_0000_0000, 64'd1, 1, 0, 0, 0, 0, "R10", 0);
    run_op(64'h0000_0000_8000_0000, 64'd1, 1, 0, 1, 0, 0, "R10", 0);
    run_op(64'h0000_0000_8000_0000, 64'd1, 1, 0, 1, 0, 1, "R10", 0);
    // R10 exemption for remainder mode with the same operands
    run_op(64'h8000_0000_0000_0000, 64'd1, 1, 0, 0, 1, 0, "R10", 0);
    // R11 request during an operation is ignored
    run_op(64'd123456789, 64'd1000, 0, 0, 0, 0, 0, "R11", 1);

    // R1 reset during an operation cancels it
    @(negedge clk);
    drive_req(64'd100, 64'd7, 0, 0, 0, 0, 0);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy, "R1", "busy after mid-op reset", 64'(busy), 64'd0);
    begin
      bit seen;
      seen = 0;
      for (int i = 0; i < 70; i++) begin
        @(negedge clk);
        if (res_valid) seen = 1;
      end
      chk(!seen, "R1", "no result after mid-op reset", 64'(seen), 64'd0);
    end

    for (int k = 0; k < 400; k++) random_op();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule